// File: doc/BRIEF.md
# Floating-point status and exception register

This block keeps the status and control word of a floating-point unit. Software can load the word through a write port with a per-bit mask. The arithmetic unit reports each completed operation with a strobe, five raw exception indications and an unimplemented-operation indication. Each report replaces the per-operation cause bits, adds them into sticky accumulated flags, and checks them against the trap enables. When an enabled cause is present, the block issues a one-cycle trap request carrying the fixed exception code 0x120.

Two control bits are decoded continuously for the datapath: one selects truncating rounding, and one selects flushing of denormal values to zero.

Register layout, LSB first:

| Bits | Field |
|------|-------|
| [1:0] | Rounding mode |
| [6:2] | Sticky flags, ordered V, Z, O, U, I from high to low |
| [11:7] | Enables, same ordering |
| [17:12] | Causes: bit 17 is the unimplemented error, bits 16..12 are V, Z, O, U, I |
| [18] | Denormal flush |

Bits 31:19 are not writable and always read zero.

Top module: `fpsr_unit`

## Requirements
- R1: After reset `rd_data` is 0, `trap_req` is 0, `trap_code` is 0, `rnd_to_zero` is 0 and `flush_dn` is 0.
- R2: A software write (`wr_en`) updates the bits where `wr_mask` is 1 with `wr_data`, then ANDs the result with 0x0007FFFF, so bits 31:19 always read 0. Bits where `wr_mask` is 0 keep their value.
- R3: `rnd_to_zero` is 1 exactly when `rd_data[1:0]` is 2'b01; the encodings 00, 10 and 11 give 0, which means round to nearest even.
- R4: `flush_dn` equals `rd_data[18]`.
- R5: After a cycle with `op_valid`=1, `rd_data[17:12]` equals `{op_unimpl, op_flags}`, where `op_flags` is ordered V,Z,O,U,I from bit 4 to bit 0. Earlier cause bits are cleared.
- R6: An operation with any raised flag ORs `op_flags` into `rd_data[6:2]`, using the same bit order. Sticky bits are never cleared by operations.
- R7: If `op_flags & rd_data[11:7]` is nonzero during a strobe, then `trap_req` is 1 for exactly the next cycle and `trap_code` is 0x120 in that cycle. At all other times `trap_req` is 0 and `trap_code` is 0.
- R8: `op_unimpl` always raises a trap, whatever the enables are. It sets cause bit 17 and does not change the sticky flags.
- R9: A strobe with no raised indication clears the cause bits only. The sticky flags stay unchanged and no trap is raised.
- R10: When `wr_en` and `op_valid` are both 1 in the same cycle, the operation update wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| op_valid | input | 1 | Operation completed strobe |
| op_flags | input | 5 | Raw V,Z,O,U,I indications (bit 4 = V) |
| op_unimpl | input | 1 | Unimplemented-operation indication |
| rd_data | output | 32 | Register readback |
| rnd_to_zero | output | 1 | Truncating rounding selected |
| flush_dn | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code, 0x120 while a trap is requested |

## Verification
The bench targets the following corner cases:

- **Stale causes.** A strobe with no flags must wipe stale causes. A design that skips the clear on a quiet operation leaves old causes visible.
- **Cause and enable mismatch.** A raised cause whose enable is off must stay silent, and a raised cause whose enable is on must trap. A design that ANDs the wrong fields either traps spuriously or never traps.
- **Sticky alignment.** The sticky flags are checked for correct alignment, and for not absorbing the unimplemented bit. A misaligned shift lands flags in the enable field.
- **Write collision.** A write that collides with a strobe must be lost. Write-mask handling is checked with partial masks and with attempts to set the read-only upper bits.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int XLEN      = 32;
    localparam int NFLG      = 5;
    localparam int NCAUSE    = NFLG + 1;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLG_LSB   = RM_LSB + RM_W;
    localparam int EN_LSB    = FLG_LSB + NFLG;
    localparam int CAUSE_LSB = EN_LSB + NFLG;
    localparam int DN_BIT    = CAUSE_LSB + NCAUSE;
    localparam int CAUSE_TO_FLG = CAUSE_LSB - FLG_LSB;
    localparam logic [XLEN-1:0] WR_KEEP = XLEN'((64'd1 << (DN_BIT + 1)) - 64'd1);
    localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;
    localparam logic [11:0] TRAP_CODE = 12'h120;

    typedef struct packed {
        logic [XLEN-1:0] csr;
        logic            trap;
    } fpsr_state_t;
endpackage

// File: rtl/fpsr_cause_enc.sv
module fpsr_cause_enc
    import fpsr_pkg::*;
(
    input  logic [NFLG-1:0]   flags_in,
    input  logic              unimpl_in,
    input  logic [NFLG-1:0]   enables,
    input  logic [NFLG-1:0]   sticky_old,
    output logic [NCAUSE-1:0] cause_new,
    output logic [NFLG-1:0]   sticky_new,
    output logic              trap_hit
);
    logic [NFLG-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < NFLG; g++) begin : g_bit
            assign sticky_new[g] = sticky_old[g] | flags_in[g];
            assign hit_vec[g]    = flags_in[g] & enables[g];
        end
    endgenerate

    assign cause_new = {unimpl_in, flags_in};
    assign trap_hit  = unimpl_in | (|hit_vec);
endmodule

// File: rtl/fpsr_ctl_dec.sv
module fpsr_ctl_dec
    import fpsr_pkg::*;
(
    input  logic [XLEN-1:0] csr,
    output logic            rnd_to_zero,
    output logic            flush_dn
);
    assign rnd_to_zero = (csr[RM_LSB +: RM_W] == RM_TRUNC);
    assign flush_dn    = csr[DN_BIT];
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [31:0]     wr_data,
    input  logic [31:0]     wr_mask,
    input  logic            op_valid,
    input  logic [4:0]      op_flags,
    input  logic            op_unimpl,
    output logic [31:0]     rd_data,
    output logic            rnd_to_zero,
    output logic            flush_dn,
    output logic            trap_req,
    output logic [11:0]     trap_code
);
    fpsr_state_t     st_d, st_q;
    logic [NCAUSE-1:0] cause_new;
    logic [NFLG-1:0]   sticky_new;
    logic              trap_hit;
    logic              any_raised;

    fpsr_cause_enc u_enc (
        .flags_in   (op_flags),
        .unimpl_in  (op_unimpl),
        .enables    (st_q.csr[EN_LSB +: NFLG]),
        .sticky_old (st_q.csr[FLG_LSB +: NFLG]),
        .cause_new  (cause_new),
        .sticky_new (sticky_new),
        .trap_hit   (trap_hit)
    );

    fpsr_ctl_dec u_dec (
        .csr         (st_q.csr),
        .rnd_to_zero (rnd_to_zero),
        .flush_dn    (flush_dn)
    );

    assign any_raised = |cause_new;

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (op_valid) begin
            st_d.csr[CAUSE_LSB +: NCAUSE] = '0;
            if (any_raised) begin
                st_d.csr[CAUSE_LSB +: NCAUSE] = cause_new;
                st_d.csr[FLG_LSB +: NFLG]     = sticky_new;
                st_d.trap                     = trap_hit;
            end
        end else if (wr_en) begin
            st_d.csr = ((st_q.csr & ~wr_mask) | (wr_data & wr_mask)) & WR_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = st_q.csr;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.trap ? TRAP_CODE : 12'h000;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [4:0]  op_flags,
    input logic        op_unimpl,
    input logic [31:0] rd_data,
    input logic        rnd_to_zero,
    input logic        flush_dn,
    input logic        trap_req,
    input logic [11:0] trap_code
);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:19] == 13'd0);
    // R3
    rnd_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_to_zero == (rd_data[1:0] == 2'b01));
    // R4
    flush_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dn == rd_data[18]);
    // R5
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rd_data[17:12] == $past({op_unimpl, op_flags}));
    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (rd_data[6:2] & $past(rd_data[6:2])) == $past(rd_data[6:2]));
    // R7
    trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid));
    // R7
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_code == (trap_req ? 12'h120 : 12'h000));
    // R8
    unimpl_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_unimpl) |=> trap_req);
    // R9
    quiet_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_unimpl && op_flags == 5'd0) |=> (!trap_req && $stable(rd_data[6:2])));
endmodule

bind fpsr_unit fpsr_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_flags   (op_flags),
    .op_unimpl  (op_unimpl),
    .rd_data    (rd_data),
    .rnd_to_zero(rnd_to_zero),
    .flush_dn   (flush_dn),
    .trap_req   (trap_req),
    .trap_code  (trap_code)
);

// File: tb/test_fpsr_unit.sv
`timescale 1ns/1ps
module test_fpsr_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] wr_mask = 0;
    logic        op_valid = 0;
    logic [4:0]  op_flags = 0;
    logic        op_unimpl = 0;
    logic [31:0] rd_data;
    logic        rnd_to_zero, flush_dn, trap_req;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_reg;

    always #4 clk = ~clk;

    fpsr_unit i_fpsr_unit (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        wr_en = 1; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 0;
        exp_reg = ((exp_reg & ~m) | (d & m)) & 32'h0007FFFF;
    endtask

    // one op strobe; returns at the negedge where the result is visible
    task automatic do_op(input logic [4:0] f, input logic u, input logic also_wr);
        logic tr;
        @(negedge clk);
        op_valid = 1; op_flags = f; op_unimpl = u;
        wr_en = also_wr; wr_data = 32'hFFFFFFFF; wr_mask = 32'hFFFFFFFF;
        tr = u | (|(f & exp_reg[11:7]));
        exp_reg[17:12] = {u, f};
        exp_reg[6:2]   = exp_reg[6:2] | f;
        @(negedge clk);
        op_valid = 0; op_flags = 0; op_unimpl = 0; wr_en = 0;
        if (tr) begin
            chk("R7 trap_req", {31'd0, trap_req}, 32'd1);
            chk("R7 trap_code", {20'd0, trap_code}, 32'h120);
        end else begin
            chk("R7/R9 no trap", {31'd0, trap_req}, 32'd0);
            chk("R7 code idle", {20'd0, trap_code}, 32'd0);
        end
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 32'd0);
        chk("R1 trap", {31'd0, trap_req}, 0);
        chk("R1 code", {20'd0, trap_code}, 0);
        chk("R1 rnd", {31'd0, rnd_to_zero}, 0);
        chk("R1 flush", {31'd0, flush_dn}, 0);
    endtask

    task automatic t_write_mask();
        do_write(32'hFFFFFFFF, 32'h0000FF00);
        chk("R2 partial", rd_data, exp_reg);
        do_write(32'h12345678, 32'hFFFF00FF);
        chk("R2 upper ro", rd_data, exp_reg);
        chk("R2 upper zero", {19'd0, rd_data[31:19]}, 0);
        do_write(32'h0, 32'hFFFFFFFF);
        chk("R2 clear", rd_data, 0);
    endtask

    task automatic t_ctl();
        for (int rm = 0; rm < 4; rm++) begin
            do_write(32'(rm), 32'h3);
            chk("R3 rounding", {31'd0, rnd_to_zero}, (rm == 1) ? 1 : 0);
        end
        do_write(32'h00040000, 32'h00040000);
        chk("R4 flush on", {31'd0, flush_dn}, 1);
        do_write(32'h0, 32'h00040000);
        chk("R4 flush off", {31'd0, flush_dn}, 0);
    endtask

    task automatic t_ops();
        do_write(32'h0, 32'hFFFFFFFF);
        do_op(5'b10001, 0, 0);
        chk("R5 cause V,I", rd_data[17:12], {26'd0, 6'b010001});
        chk("R6 sticky", rd_data, exp_reg);
        do_op(5'b00100, 0, 0);
        chk("R5 cause replaced", {26'd0, rd_data[17:12]}, {26'd0, 6'b000100});
        chk("R6 sticky or", {27'd0, rd_data[6:2]}, {27'd0, 5'b10101});
        do_op(5'b00000, 0, 0);
        chk("R9 cause cleared", {26'd0, rd_data[17:12]}, 0);
        chk("R9 sticky kept", rd_data, exp_reg);
    endtask

    task automatic t_traps();
        do_write(32'h00000000, 32'hFFFFFFFF);
        do_write(32'b01000 << 7, 32'h00000F80);
        do_op(5'b10111, 0, 0);
        chk("R7 disabled causes", rd_data, exp_reg);
        do_op(5'b01000, 0, 0);
        @(negedge clk);
        chk("R7 one-cycle pulse", {31'd0, trap_req}, 0);
        do_op(5'b00000, 1, 0);
        chk("R8 unimpl cause", {26'd0, rd_data[17:12]}, {26'd0, 6'b100000});
        chk("R8 sticky untouched", rd_data, exp_reg);
    endtask

    task automatic t_collide();
        do_write(32'h0, 32'hFFFFFFFF);
        do_op(5'b00010, 0, 1);
        chk("R10 op wins", rd_data, exp_reg);
    endtask

    initial begin
        exp_reg = 0;
        #20;
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_ctl();
        t_ops();
        t_traps();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule